// File: doc/BRIEF.md
# Variable-Length Instruction Fetch and Assembly Unit

This unit pulls instruction bytes one per cycle over an 8-bit memory port, beginning at its 16-bit program counter. The first byte of an instruction is the opcode. Its two least significant bits give the instruction length, from one to four bytes. The unit collects the bytes, most significant lane first, into a 32-bit instruction word. When the word is complete it raises a one-cycle valid strobe together with three decoded attributes: the length, a memory-transfer class flag and a word-size flag.

Memory answers through a ready input, and only cycles with ready high move a byte. After the strobe the unit waits for the consumer's acknowledge before it fetches again. A redirect input loads a new program counter at any point and throws away any half-built instruction. Execution, operand addressing, interrupts and any prefetch buffering are outside the block.

Top module: `varlen_fetch`

## Requirements
- R1: After reset, pc_o equals the RESET_PC parameter (default 0), ir_o is zero, ir_valid_o is low and mem_req_o is high.
- R2: The length reported on ir_len_o equals opcode bits 1:0 plus one: 00 gives 1 byte, 01 gives 2, 10 gives 3 and 11 gives 4. Exactly that many bytes are read.
- R3: ir_o holds the opcode in bits 31:24. The bytes that follow fill bits 23:16, then 15:8, then 7:0, in the order they were fetched. Byte lanes beyond the length read as zero.
- R4: ir_ldst_o equals opcode bit 7. ir_word_o equals opcode bit 2 when bit 7 is 1, and is 0 when bit 7 is 0.
- R5: mem_addr_o equals pc_o. A byte is taken only in a cycle where mem_req_o and mem_ready_i are both high, and pc_o rises by exactly one per byte taken. While mem_ready_i is low, pc_o holds and no instruction completes.
- R6: ir_valid_o goes high in the cycle after the final byte is taken and stays high for exactly one cycle. With ready held high, it appears N cycles after fetch starts for an N-byte instruction.
- R7: From the strobe until an acknowledge, mem_req_o stays low and pc_o holds. An acknowledge in the strobe cycle or any later cycle restarts fetch in the next cycle. An acknowledge while fetching has no effect.
- R8: A redirect loads redir_pc_i into pc_o in the next cycle and discards any partly assembled instruction. Fetch resumes from the new address even while waiting for an acknowledge. A redirect overrides a byte accepted in the same cycle.
- R9: The program counter wraps from 16'hFFFF to 16'h0000 within an instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_req_o | output | 1 | Byte fetch request |
| mem_addr_o | output | 16 | Byte address (equals pc_o) |
| mem_rdata_i | input | 8 | Byte returned by memory |
| mem_ready_i | input | 1 | Memory byte valid this cycle |
| redir_i | input | 1 | Load a new program counter |
| redir_pc_i | input | 16 | Redirect target |
| ir_ack_i | input | 1 | Consumer has taken the instruction |
| pc_o | output | 16 | Program counter |
| ir_o | output | 32 | Assembled instruction |
| ir_valid_o | output | 1 | Instruction complete, one-cycle strobe |
| ir_len_o | output | 3 | Instruction length in bytes |
| ir_ldst_o | output | 1 | Load/store/move class flag |
| ir_word_o | output | 1 | Word-size transfer flag |

## Verification
The assertions assume that mem_rdata_i is meaningful only in cycles where mem_req_o and mem_ready_i are both high. They also assume that redir_i and ir_ack_i are driven as single-cycle pulses from a clean clock domain. The stimulus drives ready from a fixed-seed random draw at the falling edge and returns bytes from a small address-indexed table, so every accepted byte is well defined. It also raises acknowledge and redirect only at falling edges, for one cycle at a time. Directed cases place chosen opcodes of each length and class at known addresses. They add a long ready stall, redirects during assembly and while waiting, and an instruction that straddles the top of the address space.

// File: rtl/vlf_pkg.sv
package vlf_pkg;
  typedef enum logic [1:0] {
    ST_FETCH = 2'd0,
    ST_DONE  = 2'd1,
    ST_WAIT  = 2'd2
  } fetch_st_e;
endpackage

// File: rtl/vlf_opdec.sv
module vlf_opdec #(
  parameter int unsigned BUS_W    = 8,
  parameter int unsigned LEN_W    = 2,
  parameter int unsigned LDST_BIT = 7,
  parameter int unsigned SIZE_BIT = 2
) (
  input  logic [BUS_W-1:0] op_i,
  output logic [LEN_W-1:0] len_m1_o,
  output logic             ldst_o,
  output logic             word_o
);
  logic unused_op;
  assign unused_op = ^op_i;

  assign len_m1_o = op_i[LEN_W-1:0];
  assign ldst_o   = op_i[LDST_BIT];
  // size bit only meaningful for transfer class
  assign word_o   = op_i[LDST_BIT] & op_i[SIZE_BIT];
endmodule

// File: rtl/vlf_pack.sv
module vlf_pack #(
  parameter int unsigned BUS_W = 8,
  parameter int unsigned LANES = 4,
  parameter int unsigned LEN_W = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [LEN_W-1:0]       idx_i,
  input  logic [BUS_W-1:0]       byte_i,
  output logic [BUS_W*LANES-1:0] ir_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BUS_W-1:0] lane_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               lane_q <= '0;
      else if (we_i && idx_i == LEN_W'(g))       lane_q <= byte_i;
      else if (we_i && idx_i == '0)              lane_q <= '0; // new opcode clears tail
    end
    assign ir_o[(LANES-g)*BUS_W-1 -: BUS_W] = lane_q;
  end
endmodule

// File: rtl/vlf_ctrl.sv
module vlf_ctrl
  import vlf_pkg::*;
#(
  parameter int unsigned      ADDR_W   = 16,
  parameter int unsigned      LEN_W    = 2,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mem_ready_i,
  input  logic              redir_i,
  input  logic [ADDR_W-1:0] redir_pc_i,
  input  logic              ack_i,
  input  logic [LEN_W-1:0]  dec_len_m1_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic              req_o,
  output logic              take_o,
  output logic [LEN_W-1:0]  idx_o,
  output logic              valid_o
);
  fetch_st_e         state_q;
  logic [ADDR_W-1:0] pc_q;
  logic [LEN_W-1:0]  cnt_q, len_q;
  logic              last;

  assign req_o   = (state_q == ST_FETCH);
  assign take_o  = req_o & mem_ready_i & ~redir_i;
  assign valid_o = (state_q == ST_DONE);
  assign idx_o   = cnt_q;
  assign pc_o    = pc_q;
  assign last    = (cnt_q == '0) ? (dec_len_m1_i == '0) : (cnt_q == len_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_FETCH;
      pc_q    <= RESET_PC;
      cnt_q   <= '0;
      len_q   <= '0;
    end else if (redir_i) begin
      state_q <= ST_FETCH;
      pc_q    <= redir_pc_i;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_FETCH: if (take_o) begin
          pc_q <= pc_q + ADDR_W'(1);
          if (cnt_q == '0) len_q <= dec_len_m1_i;
          if (last) begin
            cnt_q   <= '0;
            state_q <= ST_DONE;
          end else begin
            cnt_q <= cnt_q + LEN_W'(1);
          end
        end
        ST_DONE: state_q <= ack_i ? ST_FETCH : ST_WAIT;
        ST_WAIT: if (ack_i) state_q <= ST_FETCH;
        default: state_q <= ST_FETCH;
      endcase
    end
  end
endmodule

// File: rtl/varlen_fetch.sv
module varlen_fetch #(
  parameter int unsigned       ADDR_W   = 16,
  parameter int unsigned       BUS_W    = 8,
  parameter int unsigned       IR_BYTES = 4,
  parameter logic [ADDR_W-1:0] RESET_PC = '0,
  localparam int unsigned      LEN_W    = $clog2(IR_BYTES),
  localparam int unsigned      IR_W     = BUS_W * IR_BYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [BUS_W-1:0]  mem_rdata_i,
  input  logic              mem_ready_i,
  input  logic              redir_i,
  input  logic [ADDR_W-1:0] redir_pc_i,
  input  logic              ir_ack_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [IR_W-1:0]   ir_o,
  output logic              ir_valid_o,
  output logic [LEN_W:0]    ir_len_o,
  output logic              ir_ldst_o,
  output logic              ir_word_o
);
  logic [LEN_W-1:0] dec_len_m1, idx, len_q;
  logic             dec_ldst, dec_word, take, ldst_q, word_q;

  vlf_opdec #(.BUS_W(BUS_W), .LEN_W(LEN_W)) u_dec (
    .op_i(mem_rdata_i), .len_m1_o(dec_len_m1), .ldst_o(dec_ldst), .word_o(dec_word)
  );

  vlf_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .RESET_PC(RESET_PC)) u_ctrl (
    .clk_i, .rst_ni, .mem_ready_i, .redir_i, .redir_pc_i,
    .ack_i(ir_ack_i), .dec_len_m1_i(dec_len_m1),
    .pc_o, .req_o(mem_req_o), .take_o(take), .idx_o(idx), .valid_o(ir_valid_o)
  );

  vlf_pack #(.BUS_W(BUS_W), .LANES(IR_BYTES), .LEN_W(LEN_W)) u_pack (
    .clk_i, .rst_ni, .we_i(take), .idx_i(idx), .byte_i(mem_rdata_i), .ir_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q  <= '0;
      ldst_q <= 1'b0;
      word_q <= 1'b0;
    end else if (take && idx == '0) begin
      len_q  <= dec_len_m1;
      ldst_q <= dec_ldst;
      word_q <= dec_word;
    end
  end

  assign mem_addr_o = pc_o;
  assign ir_len_o   = {1'b0, len_q} + (LEN_W+1)'(1);
  assign ir_ldst_o  = ldst_q;
  assign ir_word_o  = word_q;

  AST_PC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ready_i && !redir_i) |=> pc_o == ADDR_W'($past(pc_o) + ADDR_W'(1))); // R5
  AST_PC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!redir_i && !(mem_req_o && mem_ready_i)) |=> $stable(pc_o)); // R5
  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ir_valid_o |=> !ir_valid_o); // R6
  AST_HOLD_FOR_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ir_valid_o && !ir_ack_i && !redir_i) |=> (!mem_req_o && $stable(pc_o))); // R7
  AST_REDIR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redir_i |=> (pc_o == $past(redir_pc_i) && mem_req_o)); // R8
  AST_SHORT_TAIL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ir_valid_o && ir_len_o == (LEN_W+1)'(1)) |-> ir_o[IR_W-BUS_W-1:0] == '0); // R3
endmodule

// File: tb/varlen_fetch_test.sv
module varlen_fetch_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_req, mem_ready = 1'b0, redir = 1'b0, ack = 1'b0;
  logic [15:0] mem_addr, redir_pc = '0, pc;
  logic [7:0]  mem_rdata;
  logic [31:0] ir;
  logic        ir_valid, ir_ldst, ir_word;
  logic [2:0]  ir_len;
  logic [7:0]  mem [256];
  int          n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  assign mem_rdata = mem[mem_addr[7:0]];

  varlen_fetch uut (
    .clk_i(clk), .rst_ni(rst_n), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rdata_i(mem_rdata), .mem_ready_i(mem_ready), .redir_i(redir),
    .redir_pc_i(redir_pc), .ir_ack_i(ack), .pc_o(pc), .ir_o(ir),
    .ir_valid_o(ir_valid), .ir_len_o(ir_len), .ir_ldst_o(ir_ldst), .ir_word_o(ir_word)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_ir(input logic [15:0] a);
    logic [31:0] r = '0;
    logic [7:0]  op = mem[a[7:0]];
    int          n = int'(op[1:0]) + 1;
    for (int k = 0; k < n; k++) begin
      logic [15:0] ak = a + 16'(k);
      r[31-8*k -: 8] = mem[ak[7:0]];
    end
    return r;
  endfunction

  // ack_mode: 0 ack in strobe cycle, 1 delayed ack, 2 leave unacked
  task automatic fetch_one(input logic [15:0] start, input int ready_pct, input int ack_mode);
    logic [7:0]  op = mem[start[7:0]];
    int          n = int'(op[1:0]) + 1;
    logic [31:0] e = exp_ir(start);
    logic [15:0] ppc;
    bit          ptake, got = 0;
    int          bad = 0, cyc = 0;
    for (int c = 0; c < 300 && !got; c++) begin
      mem_ready = ($urandom % 100) < ready_pct;
      ptake = mem_req && mem_ready;
      ppc = pc;
      @(negedge clk);
      cyc++;
      if (pc != (ptake ? 16'(ppc + 16'd1) : ppc)) bad++;
      if (ir_valid) got = 1;
    end
    mem_ready = 1'b0;
    chk(got, "R6", "valid strobe seen", 32'(got), 1);
    if (ready_pct == 100) chk(cyc == n, "R6", "latency with ready high", cyc, n);
    chk(bad == 0, "R5", "pc steps per taken byte", bad, 0);
    chk(ir == e, "R3", "packed word", ir, e);
    chk(ir_len == 3'(n), "R2", "length", ir_len, n);
    chk(ir_ldst == op[7], "R4", "class flag", ir_ldst, op[7]);
    chk(ir_word == (op[7] & op[2]), "R4", "word flag", ir_word, op[7] & op[2]);
    chk(pc == 16'(start + 16'(n)), "R5", "pc after instruction", pc, 16'(start + 16'(n)));
    if (ack_mode == 0) begin
      ack = 1'b1;
      @(negedge clk);
      ack = 1'b0;
      chk(!ir_valid, "R6", "strobe one cycle", ir_valid, 0);
      chk(mem_req, "R7", "restart after ack in strobe cycle", mem_req, 1);
    end else if (ack_mode == 1) begin
      ppc = pc;
      repeat (2) begin
        @(negedge clk);
        chk(!ir_valid, "R6", "strobe one cycle", ir_valid, 0);
        chk(!mem_req && pc == ppc, "R7", "idle until ack", {mem_req, pc}, {1'b0, ppc});
      end
      ack = 1'b1;
      @(negedge clk);
      ack = 1'b0;
      chk(mem_req, "R7", "restart after late ack", mem_req, 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] ppc;
    void'($urandom(32'd2024));
    for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
    mem[0] = 8'h00;                                              // 1 byte
    mem[1] = 8'h87; mem[2] = 8'h12; mem[3] = 8'h34; mem[4] = 8'h56; // 4 byte, word
    mem[5] = 8'h8A; mem[6] = 8'hAB; mem[7] = 8'hCD;             // 3 byte, byte mode
    mem[8] = 8'h35; mem[9] = 8'h77;                              // 2 byte, bit2 set, not transfer
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pc == 16'h0 && ir == '0 && !ir_valid && mem_req, "R1", "reset state",
        {pc, 7'(ir), ir_valid, mem_req}, {16'h0, 7'h0, 1'b0, 1'b1});

    fetch_one(16'd0, 100, 0);
    fetch_one(16'd1, 100, 1);
    fetch_one(16'd5, 100, 0);
    fetch_one(16'd8, 60, 1);

    // ack while fetching is ignored
    ack = 1'b1; @(negedge clk); ack = 1'b0;
    chk(mem_req && !ir_valid, "R7", "ack during fetch ignored", {mem_req, ir_valid}, 2'b10);
    fetch_one(pc, 100, 0);

    // ready stall
    ppc = pc;
    repeat (5) @(negedge clk);
    chk(pc == ppc && !ir_valid, "R5", "stall holds pc", pc, ppc);

    for (int t = 0; t < 40; t++) fetch_one(pc, 70, int'($urandom % 2));

    // redirect mid-instruction, ready high in the redirect cycle
    mem[pc[7:0]] = 8'h8F;
    mem_ready = 1'b1;
    repeat (2) @(negedge clk);
    redir = 1'b1; redir_pc = 16'h0040;
    @(negedge clk);
    redir = 1'b0; mem_ready = 1'b0;
    chk(pc == 16'h0040 && mem_addr == 16'h0040 && !ir_valid, "R8", "redirect load",
        pc, 16'h0040);
    mem[8'h40] = 8'h31;
    fetch_one(16'h0040, 100, 0);
    chk(ir[15:0] == 16'h0, "R8", "partial bytes discarded", ir[15:0], 0);

    // redirect while waiting for ack
    fetch_one(pc, 100, 2);
    redir = 1'b1; redir_pc = 16'h0080;
    @(negedge clk);
    redir = 1'b0;
    chk(pc == 16'h0080 && mem_req, "R8", "redirect from wait", {pc, mem_req}, {16'h0080, 1'b1});
    fetch_one(16'h0080, 100, 0);

    // wrap across top of space
    redir = 1'b1; redir_pc = 16'hFFFE;
    @(negedge clk);
    redir = 1'b0;
    mem[8'hFE] = 8'hC3;
    fetch_one(16'hFFFE, 100, 1);
    chk(pc == 16'h0002, "R9", "pc wrap", pc, 16'h0002);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule